// File: doc/BRIEF.md
# UART Receive Error Status Unit

This block works next to a UART receive shift register. While a frame arrives, it votes each oversampled bit for the shift register. It also keeps a running record of whether any bit's samples disagreed. When the shift register reports a finished frame, the unit loads the assembled word into a receive data register and raises a data-available flag. On that same edge it sets three read-only error flags for the frame: noise, framing and parity.

A host reads the flags through a status-read strobe and the word through a data-read strobe. A data read always clears data-available. The error flags clear only when a data read comes after a status read, and that status read must have been made against the frame now held. A noisy frame is still delivered. Noise has no event of its own, because it always rises together with data-available.

Top module: `uart_rx_errstat`

## Requirements
- R1: Sample counting restarts at index 0 on a `sampleTick` that has `bitStart` high. `voteBit` is the majority of the samples at indices 7, 8 and 9, and `voteValid` pulses for one cycle on the clock edge that follows the index-9 sample.
- R2: If the three voted samples of any bit since the previous frame load were not all equal, `noiseErr` is set on the same edge at which `frameDone` loads the frame and `dataAvail` rises. A clean frame that follows a noisy one gives `noiseErr` = 0.
- R3: A frame is loaded into `rxData` on `frameDone` whether or not it was noisy.
- R4: `frameErr` is set when `frameStop[0]` is 0. When `twoStop` = 1 it is also set when `frameStop[1]` is 0.
- R5: When `parityEn` = 1, `parityErr` is set if `frameParity` differs from the expected bit. The expected bit is the XOR of the data bits when `parityOdd` = 0 and its inverse when `parityOdd` = 1. When `parityEn` = 0, `parityErr` is 0.
- R6: A `dataRead` clears `dataAvail` on the next edge.
- R7: A `dataRead` clears all three error flags only if a `statusRead` came before it since the last frame load. A `dataRead` without that leaves the flags unchanged.
- R8: A frame load that occurs between a `statusRead` and a `dataRead` cancels the armed clear.
- R9: After reset, `rxData`, `dataAvail`, `noiseErr`, `frameErr`, `parityErr` and `voteValid` are all 0.
- R10: When `frameDone` and `dataRead` occur in the same cycle, the new frame is loaded and `dataAvail` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | One oversample of the receive line |
| bitStart | input | 1 | Marks the tick that is sample 0 of a bit |
| rxLine | input | 1 | Receive line value |
| parityEn | input | 1 | Parity check enable |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| twoStop | input | 1 | 1 = two stop bits checked |
| frameDone | input | 1 | Frame-complete strobe from the shift register |
| frameData | input | DATA_W | Assembled data word |
| frameParity | input | 1 | Received parity bit |
| frameStop | input | 2 | Received stop bits, bit 0 first |
| statusRead | input | 1 | Host status-register read strobe |
| dataRead | input | 1 | Host data-register read strobe |
| rxData | output | DATA_W | Receive data register |
| dataAvail | output | 1 | Receive data available |
| noiseErr | output | 1 | Noise flag |
| frameErr | output | 1 | Framing error flag |
| parityErr | output | 1 | Parity error flag |
| voteBit | output | 1 | Voted bit value |
| voteValid | output | 1 | One-cycle strobe for `voteBit` |

## Verification
`voteBit` and `voteValid` appear one edge after the index-9 sample tick. `rxData`, `dataAvail` and the three flags change one edge after `frameDone`. A read strobe clears its targets one edge after the strobe. The bench drives its inputs on falling edges, so each result is sampled on the falling edge that follows the rising edge that registers it, exactly one cycle after the stimulus. The vote strobe is checked within the sample-tick loop on the falling edge right after the index-9 tick.

// File: rtl/uart_rx_errstat_pkg.sv
package uart_rx_errstat_pkg;
  typedef struct packed {
    logic grabEarly;   // capture the first voted sample
    logic grabMid;     // capture the middle voted sample
    logic voteNow;     // last voted sample present, resolve the bit
    logic loadFrame;   // move the completed word and flags in
    logic clearErr;    // armed clear of the error flags
    logic clearAvail;  // data register read
  } rxStrobe_t;
endpackage

// File: rtl/uart_rx_errstat_ctrl.sv
module uart_rx_errstat_ctrl
  import uart_rx_errstat_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int VOTE_MID = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sampleTick,
  input  logic       bitStart,
  input  logic       frameDone,
  input  logic       statusRead,
  input  logic       dataRead,
  output rxStrobe_t  strobe
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] IDX_EARLY = CNT_W'(VOTE_MID - 1);
  localparam logic [CNT_W-1:0] IDX_MID   = CNT_W'(VOTE_MID);
  localparam logic [CNT_W-1:0] IDX_LATE  = CNT_W'(VOTE_MID + 1);
  localparam logic [CNT_W-1:0] IDX_LAST  = CNT_W'(OVS - 1);

  logic [CNT_W-1:0] sampleCnt;
  logic [CNT_W-1:0] curIdx;
  logic             armed;

  assign curIdx = bitStart ? '0 : sampleCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampleCnt <= IDX_LAST;
    end else if (sampleTick) begin
      sampleCnt <= (curIdx == IDX_LAST) ? IDX_LAST : curIdx + 1'b1;
    end
  end

  // Status read arms the clear; a data read or a new frame consumes it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (frameDone || dataRead) begin
      armed <= 1'b0;
    end else if (statusRead) begin
      armed <= 1'b1;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.grabEarly  = sampleTick && (curIdx == IDX_EARLY);
    strobe.grabMid    = sampleTick && (curIdx == IDX_MID);
    strobe.voteNow    = sampleTick && (curIdx == IDX_LATE);
    strobe.loadFrame  = frameDone;
    strobe.clearAvail = dataRead;
    strobe.clearErr   = dataRead && armed && !frameDone;
  end

  // R8: a frame load always leaves the clear disarmed
  p_frame_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |=> !armed);

  // R7: arming only follows a status read
  p_arm_from_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(statusRead));
endmodule

// File: rtl/uart_rx_errstat_dp.sv
module uart_rx_errstat_dp
  import uart_rx_errstat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rxStrobe_t         strobe,
  input  logic              rxLine,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameParity,
  input  logic [1:0]        frameStop,
  output logic [DATA_W-1:0] rxData,
  output logic              dataAvail,
  output logic              noiseErr,
  output logic              frameErr,
  output logic              parityErr,
  output logic              voteBit,
  output logic              voteValid
);
  logic sEarly, sMid;
  logic majority, disagree;
  logic frameNoise;
  logic stopBad, parityBad, expParity;

  assign majority  = (sEarly & sMid) | (sEarly & rxLine) | (sMid & rxLine);
  assign disagree  = !((sEarly == sMid) && (sMid == rxLine));
  assign stopBad   = !frameStop[0] || (twoStop && !frameStop[1]);
  assign expParity = (^frameData) ^ parityOdd;
  assign parityBad = parityEn && (frameParity != expParity);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sEarly    <= 1'b0;
      sMid      <= 1'b0;
      voteBit   <= 1'b0;
      voteValid <= 1'b0;
    end else begin
      if (strobe.grabEarly) sEarly <= rxLine;
      if (strobe.grabMid)   sMid   <= rxLine;
      if (strobe.voteNow)   voteBit <= majority;
      voteValid <= strobe.voteNow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frameNoise <= 1'b0;
    end else if (strobe.loadFrame) begin
      frameNoise <= strobe.voteNow && disagree;
    end else if (strobe.voteNow) begin
      frameNoise <= frameNoise | disagree;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxData    <= '0;
      dataAvail <= 1'b0;
      noiseErr  <= 1'b0;
      frameErr  <= 1'b0;
      parityErr <= 1'b0;
    end else if (strobe.loadFrame) begin
      rxData    <= frameData;
      dataAvail <= 1'b1;
      noiseErr  <= frameNoise;
      frameErr  <= stopBad;
      parityErr <= parityBad;
    end else begin
      if (strobe.clearAvail) dataAvail <= 1'b0;
      if (strobe.clearErr) begin
        noiseErr  <= 1'b0;
        frameErr  <= 1'b0;
        parityErr <= 1'b0;
      end
    end
  end

  // R1: a vote strobe follows a sample tick
  p_vote_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    voteValid |-> $past(strobe.voteNow));

  // R5: a frame loaded with parity disabled never reports a parity error
  p_parity_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadFrame && !parityEn) |=> !parityErr);

  // R2: the noise flag only rises together with a frame load
  p_noise_with_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(noiseErr) |-> $past(strobe.loadFrame) && dataAvail);

  // R6: a read without a new frame drops data-available
  p_avail_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.clearAvail && !strobe.loadFrame) |=> !dataAvail);
endmodule

// File: rtl/uart_rx_errstat.sv
module uart_rx_errstat
  import uart_rx_errstat_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int VOTE_MID = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleTick,
  input  logic              bitStart,
  input  logic              rxLine,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic              frameDone,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameParity,
  input  logic [1:0]        frameStop,
  input  logic              statusRead,
  input  logic              dataRead,
  output logic [DATA_W-1:0] rxData,
  output logic              dataAvail,
  output logic              noiseErr,
  output logic              frameErr,
  output logic              parityErr,
  output logic              voteBit,
  output logic              voteValid
);
  rxStrobe_t strobe;

  uart_rx_errstat_ctrl #(.OVS(OVS), .VOTE_MID(VOTE_MID)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sampleTick(sampleTick), .bitStart(bitStart),
    .frameDone(frameDone), .statusRead(statusRead), .dataRead(dataRead),
    .strobe(strobe)
  );

  uart_rx_errstat_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rxLine(rxLine),
    .parityEn(parityEn), .parityOdd(parityOdd), .twoStop(twoStop),
    .frameData(frameData), .frameParity(frameParity), .frameStop(frameStop),
    .rxData(rxData), .dataAvail(dataAvail), .noiseErr(noiseErr),
    .frameErr(frameErr), .parityErr(parityErr), .voteBit(voteBit),
    .voteValid(voteValid)
  );

  // R7: without a frame load or a data read, the flags hold
  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!frameDone && !dataRead) |=>
      $stable(noiseErr) && $stable(frameErr) && $stable(parityErr));
endmodule

// File: tb/uart_rx_errstat_tb_top.sv
module uart_rx_errstat_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleTick = 0, bitStart = 0, rxLine = 1;
  logic parityEn = 0, parityOdd = 0, twoStop = 0;
  logic frameDone = 0, frameParity = 0;
  logic [7:0] frameData = '0;
  logic [1:0] frameStop = 2'b11;
  logic statusRead = 0, dataRead = 0;
  logic [7:0] rxData;
  logic dataAvail, noiseErr, frameErr, parityErr, voteBit, voteValid;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_errstat dut_i (
    .clk(clk), .rst_n(rst_n), .sampleTick(sampleTick), .bitStart(bitStart),
    .rxLine(rxLine), .parityEn(parityEn), .parityOdd(parityOdd),
    .twoStop(twoStop), .frameDone(frameDone), .frameData(frameData),
    .frameParity(frameParity), .frameStop(frameStop),
    .statusRead(statusRead), .dataRead(dataRead), .rxData(rxData),
    .dataAvail(dataAvail), .noiseErr(noiseErr), .frameErr(frameErr),
    .parityErr(parityErr), .voteBit(voteBit), .voteValid(voteValid)
  );

  // vector: data, parity bit, stop[1:0], pEn, pOdd, twoStop, noisy, expF, expP
  typedef struct packed {
    logic [7:0] data;
    logic       par;
    logic [1:0] stop;
    logic       pEn;
    logic       pOdd;
    logic       two;
    logic       noisy;
    logic       expF;
    logic       expP;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'hA5, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'hA5, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{8'hA5, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{8'h07, 1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{8'h07, 1'b1, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{8'h3C, 1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{8'hFF, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bit of 16 ticks; samples 7,8,9 given, others follow the middle one
  task automatic sendBit(input logic a, input logic b, input logic c);
    for (int i = 0; i < 16; i++) begin
      sampleTick = 1'b1;
      bitStart   = (i == 0);
      rxLine     = (i == 7) ? a : (i == 9) ? c : b;
      @(negedge clk);
      if (i == 9) begin
        chk("R1 voteValid", voteValid, 1);
        chk("R1 voteBit", voteBit, (a & b) | (a & c) | (b & c));
      end
      if (i == 10) chk("R1 voteValid one cycle", voteValid, 0);
    end
    sampleTick = 1'b0;
    bitStart   = 1'b0;
  endtask

  task automatic loadFrame(input logic [7:0] d, input logic p, input logic [1:0] s);
    frameData = d; frameParity = p; frameStop = s;
    frameDone = 1'b1;
    @(negedge clk);
    frameDone = 1'b0;
  endtask

  task automatic pulseStatus();
    statusRead = 1'b1; @(negedge clk); statusRead = 1'b0;
  endtask

  task automatic pulseData();
    dataRead = 1'b1; @(negedge clk); dataRead = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 rxData", rxData, 0);
    chk("R9 dataAvail", dataAvail, 0);
    chk("R9 flags", {noiseErr, frameErr, parityErr}, 0);
    chk("R9 voteValid", voteValid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector walk: R1..R7
    for (int v = 0; v < NVEC; v++) begin
      parityEn = VECS[v].pEn; parityOdd = VECS[v].pOdd; twoStop = VECS[v].two;
      sendBit(1'b0, 1'b0, 1'b0);
      if (VECS[v].noisy) sendBit(1'b1, 1'b0, 1'b1);
      else sendBit(1'b1, 1'b1, 1'b1);
      loadFrame(VECS[v].data, VECS[v].par, VECS[v].stop);
      chk("R3 rxData", rxData, VECS[v].data);
      chk("R2 dataAvail", dataAvail, 1);
      chk("R2 noiseErr", noiseErr, VECS[v].noisy);
      chk("R4 frameErr", frameErr, VECS[v].expF);
      chk("R5 parityErr", parityErr, VECS[v].expP);
      pulseStatus();
      pulseData();
      chk("R6 dataAvail cleared", dataAvail, 0);
      chk("R7 flags cleared", {noiseErr, frameErr, parityErr}, 0);
    end

    // R1 minority disagreement votes to zero and marks noise
    sendBit(1'b0, 1'b1, 1'b0);
    sendBit(1'b0, 1'b0, 1'b1);
    twoStop = 1'b0; parityEn = 1'b0;
    loadFrame(8'h5A, 1'b0, 2'b00);
    chk("R2 noise from minority", noiseErr, 1);
    chk("R3 noisy data delivered", rxData, 8'h5A);

    // R7 data read alone keeps flags, clears availability
    pulseData();
    chk("R6 avail after lone read", dataAvail, 0);
    chk("R7 flags kept after lone read", {noiseErr, frameErr}, 2'b11);
    pulseStatus();
    @(negedge clk);
    pulseData();
    chk("R7 flags cleared after gap", {noiseErr, frameErr, parityErr}, 0);

    // R8 frame load between status and data read cancels the clear
    loadFrame(8'h11, 1'b0, 2'b00);
    pulseStatus();
    loadFrame(8'h22, 1'b0, 2'b00);
    pulseData();
    chk("R8 frameErr kept", frameErr, 1);
    chk("R8 noiseErr clean frame", noiseErr, 0);
    chk("R8 data", rxData, 8'h22);

    // R10 frame load and data read in the same cycle
    frameData = 8'h33; frameParity = 0; frameStop = 2'b11;
    frameDone = 1'b1; dataRead = 1'b1;
    @(negedge clk);
    frameDone = 1'b0; dataRead = 1'b0;
    chk("R10 dataAvail stays", dataAvail, 1);
    chk("R10 new data", rxData, 8'h33);
    chk("R10 frameErr of new frame", frameErr, 0);

    // R9 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset clears data", rxData, 0);
    chk("R9 reset clears avail", dataAvail, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule